// File: doc/BRIEF.md
# Read Strobe Postamble Gate

This block sits between the read data strobe pins and the capture flops of a double-data-rate read path. It opens a window only while a read burst is on the wire, so the capture flops see the strobe edges that belong to the burst. When the window is shut, the gated strobe is forced low. Glitches while the strobe is low after the last data edge, or while it drifts back to high impedance, then cannot clock in false data. Here the preamble is the low stretch just after the strobe leaves high impedance, and the postamble is the low stretch just before it returns there.

The window request comes from one of two sources, chosen by a mode pin. In half-rate mode the controller hands over one word per half-rate period, with one bit per full-rate slot. A serializing register stage plays the word out one slot per cycle. In direct mode a single enable bit from core logic is sampled on each full-rate clock edge. The chosen bit goes through a rising-edge flop and a falling-edge copy of it, and the two outputs are ANDed. Opening the window therefore waits half a cycle, and closing it takes effect on the same rising edge. A burst that is not back-to-back with the previous one therefore never inherits a late enable from it. One window serves every strobe lane of the group.

Top module: `rs_postamble_gate`

## Requirements
- R1: Each lane of `dqs_gated` equals the same lane of `dqs_in` while the window is open, and is 0 while it is shut.
- R2: When the selected enable bit is taken as 1 at a rising edge after a cycle at 0, the window stays shut until the following falling edge of `clk`, and opens there (half a cycle of assertion latency).
- R3: When the selected enable bit is taken as 0 at a rising edge, the window is shut immediately after that same rising edge (no added deassertion latency).
- R4: With `src_sel` = 0 (half-rate mode), the period counter restarts at slot 0 on the first rising edge after reset and closes a period every SLOTS edges. On the edge where slot SLOTS-1 ends, `hr_req` is taken as the next word. Bit j of that word (bit 0 first) is the enable taken at the (j+1)-th rising edge that follows.
- R5: With `src_sel` = 1 (direct mode), `core_en` is taken as the enable at every rising edge.
- R6: Enable bits that are 1 in consecutive slots, including across a word boundary, keep the window open without a gap at any clock edge.
- R7: A single 0 slot between two bursts shuts the window for that entire cycle, including the half cycle before the next burst opens it, so no edge of the earlier burst leaks into the later one.
- R8: While `rst` is high, and at the first sample after it, the window is shut and every lane of `dqs_gated` is 0 even with `dqs_in` high.
- R9: In direct mode `hr_req` has no effect on the window, and in half-rate mode `core_en` has no effect. The period counter and word capture keep running in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate resynchronization clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 1 | Enable source: 0 half-rate word, 1 direct core bit |
| hr_req | input | SLOTS | Half-rate enable word, bit 0 plays first |
| core_en | input | 1 | Direct enable from core logic |
| dqs_in | input | STROBES | Raw read strobes |
| dqs_gated | output | STROBES | Strobes gated by the read window |

## Verification
The bench builds the block with SLOTS = 4 and STROBES = 2. The four-slot word lets a burst start and end in the middle of a word and lets a run of ones cross a word boundary. Two lanes show that one window gates every strobe of the group alike. Outputs are sampled twice per cycle, once between the rising and falling edge and once after the falling edge. This makes the half-cycle opening delay and the immediate close both visible at the ports.

// File: rtl/rs_gate_pkg.sv
package rs_gate_pkg;

  typedef enum logic {
    SRC_HALF_RATE = 1'b0,
    SRC_CORE      = 1'b1
  } win_src_e;

  function automatic int unsigned slot_bits(input int unsigned slots);
    return (slots > 1) ? $clog2(slots) : 1;
  endfunction

endpackage

// File: rtl/rs_slot_counter.sv
module rs_slot_counter #(
  parameter int unsigned SLOTS = 4,
  parameter int unsigned PW    = rs_gate_pkg::slot_bits(SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [PW-1:0] slot,
  output logic          period_end
);

  localparam logic [PW-1:0] LAST_SLOT = PW'(SLOTS - 1);

  logic [PW-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
    end else if (slot_q == LAST_SLOT) begin
      slot_q <= '0;
    end else begin
      slot_q <= slot_q + PW'(1);
    end
  end

  assign slot       = slot_q;
  assign period_end = (slot_q == LAST_SLOT);

endmodule

// File: rtl/rs_word_serializer.sv
module rs_word_serializer #(
  parameter int unsigned SLOTS = 4,
  parameter int unsigned PW    = rs_gate_pkg::slot_bits(SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [SLOTS-1:0] word_in,
  input  logic [PW-1:0]    slot,
  output logic [SLOTS-1:0] held,
  output logic             slot_bit
);

  logic [SLOTS-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= '0;
    end else if (take) begin
      held_q <= word_in;
    end
  end

  assign held     = held_q;
  assign slot_bit = held_q[slot];

endmodule

// File: rtl/rs_window_gate.sv
module rs_window_gate #(
  parameter int unsigned STROBES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               src_sel,
  input  logic               hr_bit,
  input  logic               core_bit,
  input  logic [STROBES-1:0] strobe_in,
  output logic [STROBES-1:0] strobe_out,
  output logic               win_pos,
  output logic               win_neg,
  output logic               win_open
);

  import rs_gate_pkg::*;

  win_src_e src;
  logic     pick;
  logic     pos_q;
  logic     neg_q;

  assign src  = win_src_e'(src_sel);
  assign pick = (src == SRC_CORE) ? core_bit : hr_bit;

  always_ff @(posedge clk) begin
    if (rst) pos_q <= 1'b0;
    else     pos_q <= pick;
  end

  always_ff @(negedge clk) begin
    if (rst) neg_q <= 1'b0;
    else     neg_q <= pos_q;
  end

  assign win_pos  = pos_q;
  assign win_neg  = neg_q;
  assign win_open = pos_q & neg_q;

  for (genvar g = 0; g < STROBES; g++) begin : g_lane
    assign strobe_out[g] = strobe_in[g] & win_open;
  end

endmodule

// File: rtl/rs_postamble_gate.sv
module rs_postamble_gate #(
  parameter int unsigned SLOTS   = 4,
  parameter int unsigned STROBES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               src_sel,
  input  logic [SLOTS-1:0]   hr_req,
  input  logic               core_en,
  input  logic [STROBES-1:0] dqs_in,
  output logic [STROBES-1:0] dqs_gated
);

  localparam int unsigned PW = rs_gate_pkg::slot_bits(SLOTS);

  logic [PW-1:0]    slot;
  logic             period_end;
  logic [SLOTS-1:0] held;
  logic             hr_bit;
  logic             win_pos;
  logic             win_neg;
  logic             win_open;

  rs_slot_counter #(.SLOTS(SLOTS), .PW(PW)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .slot       (slot),
    .period_end (period_end)
  );

  rs_word_serializer #(.SLOTS(SLOTS), .PW(PW)) u_ser (
    .clk      (clk),
    .rst      (rst),
    .take     (period_end),
    .word_in  (hr_req),
    .slot     (slot),
    .held     (held),
    .slot_bit (hr_bit)
  );

  rs_window_gate #(.STROBES(STROBES)) u_gate (
    .clk        (clk),
    .rst        (rst),
    .src_sel    (src_sel),
    .hr_bit     (hr_bit),
    .core_bit   (core_en),
    .strobe_in  (dqs_in),
    .strobe_out (dqs_gated),
    .win_pos    (win_pos),
    .win_neg    (win_neg),
    .win_open   (win_open)
  );

endmodule

// File: rtl/rs_postamble_gate_chk.sv
module rs_postamble_gate_chk #(
  parameter int unsigned SLOTS = 4,
  parameter int unsigned PW    = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             src_sel,
  input logic             core_en,
  input logic [SLOTS-1:0] hr_req,
  input logic [PW-1:0]    slot,
  input logic [SLOTS-1:0] held,
  input logic             win_pos,
  input logic             win_open
);

  localparam logic [PW-1:0] LAST_SLOT = PW'(SLOTS - 1);

  // R8: the window is shut after a reset edge
  p_reset_shut_r8: assert property (@(posedge clk) rst |=> !win_pos);

  // R5: direct mode takes core_en at the edge
  p_direct_follow_r5: assert property (@(posedge clk) disable iff (rst)
    src_sel |=> (win_pos == $past(core_en)));

  // R4: the word is captured at the period-closing edge
  p_word_take_r4: assert property (@(posedge clk) disable iff (rst)
    (slot == LAST_SLOT) |=> (held == $past(hr_req)) && (slot == '0));

  // R2: a fresh enable is not yet visible before the falling edge
  p_half_cycle_open_r2: assert property (@(negedge clk) disable iff (rst)
    $rose(win_pos) |-> !win_open);

  // R6: consecutive enabled cycles keep the window open
  p_no_gap_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(win_open) && win_pos) |-> win_open);

endmodule

bind rs_postamble_gate rs_postamble_gate_chk #(.SLOTS(SLOTS), .PW(PW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .src_sel  (src_sel),
  .core_en  (core_en),
  .hr_req   (hr_req),
  .slot     (slot),
  .held     (held),
  .win_pos  (win_pos),
  .win_open (win_open)
);

// File: tb/tb_rs_postamble_gate.sv
module tb_rs_postamble_gate;

  localparam int S = 4;
  localparam int L = 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         src_sel = 1'b0;
  logic [S-1:0] hr_req = '0;
  logic         core_en = 1'b0;
  logic [L-1:0] dqs_in = '0;
  logic [L-1:0] dqs_gated;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench model state
  logic [S-1:0] m_hold = '0;
  logic         m_en = 1'b0;
  logic         m_prev = 1'b0;
  int           m_cnt = 0;
  string        tag = "";

  always #5 clk = ~clk;

  rs_postamble_gate #(.SLOTS(S), .STROBES(L)) dut (
    .clk       (clk),
    .rst       (rst),
    .src_sel   (src_sel),
    .hr_req    (hr_req),
    .core_en   (core_en),
    .dqs_in    (dqs_in),
    .dqs_gated (dqs_gated)
  );

  function automatic logic [L-1:0] gate_exp(input logic [L-1:0] s, input logic w);
    return w ? s : '0;
  endfunction

  task automatic check(input string req, input logic [L-1:0] got, input logic [L-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s t=%0t got=%b exp=%b", req, $time, got, exp);
    end
  endtask

  // one full-rate cycle: edge, model update, early and late samples, next drive
  task automatic cycle(input logic sel, input logic fab, input logic [S-1:0] req);
    int p;
    logic nxt;
    string t_early;
    @(posedge clk);
    p = m_cnt % S;
    nxt = src_sel ? core_en : m_hold[p];
    if (p == S - 1) m_hold = hr_req;
    m_prev = m_en;
    m_en = nxt;
    m_cnt++;
    #1 dqs_in = L'($urandom);
    #1;
    if (tag != "") t_early = tag;
    else if (m_en && !m_prev) t_early = "R2";
    else if (!m_en && m_prev) t_early = "R3";
    else t_early = src_sel ? "R5" : "R4";
    check(t_early, dqs_gated, gate_exp(dqs_in, m_en & m_prev));
    #4 dqs_in = L'($urandom);
    #1 check((tag != "") ? tag : "R1", dqs_gated, gate_exp(dqs_in, m_en));
    #1;
    src_sel = sel;
    core_en = fab;
    hr_req = req;
  endtask

  initial begin
    // R8: reset holds the window shut
    dqs_in = '1;
    repeat (3) begin
      @(posedge clk);
      #3 check("R8", dqs_gated, '0);
    end
    #1 rst = 1'b0;
    #1 check("R8", dqs_gated, '0);

    // R4: single mid-word burst in half-rate mode
    tag = "";
    cycle(1'b0, 1'b0, 4'b0110);
    cycle(1'b0, 1'b0, 4'b0000);
    cycle(1'b0, 1'b0, 4'b0000);
    cycle(1'b0, 1'b0, 4'b0000);
    repeat (8) cycle(1'b0, 1'b0, 4'b0000);

    // R6: back-to-back words of ones, window must stay open across boundaries
    m_cnt = m_cnt;
    tag = "";
    repeat (4) cycle(1'b0, 1'b0, 4'b1111);
    tag = "R6";
    repeat (8) cycle(1'b0, 1'b0, 4'b1111);
    tag = "";
    repeat (8) cycle(1'b0, 1'b0, 4'b0000);

    // R7: non-consecutive bursts separated by a single zero slot
    tag = "R7";
    repeat (4) cycle(1'b0, 1'b0, 4'b1011);
    repeat (4) cycle(1'b0, 1'b0, 4'b1101);
    repeat (8) cycle(1'b0, 1'b0, 4'b0000);

    // R5 and R9: direct mode with hr_req toggling and ignored
    tag = "R9";
    repeat (2) cycle(1'b1, 1'b0, 4'b1111);
    cycle(1'b1, 1'b1, 4'b1111);
    cycle(1'b1, 1'b1, 4'b0000);
    cycle(1'b1, 1'b0, 4'b1111);
    cycle(1'b1, 1'b1, 4'b1111);
    cycle(1'b1, 1'b0, 4'b1111);
    repeat (4) cycle(1'b1, 1'b0, 4'b1111);
    // R9: core_en ignored in half-rate mode
    repeat (12) cycle(1'b0, 1'b1, 4'b0000);

    // mixed random traffic, fixed seed
    tag = "";
    void'($urandom(32'h5eed_0a11));
    for (int i = 0; i < 400; i++) begin
      logic sel_r;
      sel_r = ($urandom % 4) == 0;
      cycle(sel_r, 1'($urandom), S'($urandom));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule